// File: doc/BRIEF.md
# Management Mode Context Switch Unit

This block moves a processor core into a hidden management mode and back out again. Four sources can ask for entry: an external management interrupt pin, a decoded break instruction, a privilege monitor event and an opcode trap. A decoded return instruction asks for the way back. On entry the unit copies six items of live core state into a bank of numbered shadow slots. It records which source won. It then hands the core a forced state that puts it in a 16-bit real-mode context with paging and interrupts off, and it redirects the core to an entry address built from a page register that software writes.

On return the unit hands the six saved items back to the core, and the core then resumes normal operation. Every other piece of core state is left to software. While the core is in management mode, software can read the shadow slots through a read port that is indexed by slot number. A request that arrives while the core is already in management mode is held. It is taken in the cycle after the return is signalled.

Top module: `mmcs_top`

## Requirements
- R1: When several requests are present at once, the unit takes one in this fixed order: external pin, then privilege monitor, then opcode trap, then break instruction. The winner is recorded in shadow slot 26 as the code 1 (pin), 2 (monitor), 3 (trap) or 4 (break).
- R2: On entry the unit saves six items into shadow slots. CR0 goes to slot 31, EFLAGS to slot 30, the CS limit to slot 29, the CS base to slot 28, EIP to slot 27 and the CS selector, zero-extended, to slot 25.
- R3: In the redirect cycle the unit drives this forced state. outCr0 is the live CR0 with bit 0 (protection enable) and bit 31 (paging) cleared. outEflags is the live EFLAGS with bit 9 (interrupt enable) cleared. outCsBase equals the page register, outCsLimit is 0000FFFFh, outCsSel is page bits 19:4 and outEip is 0000FF90h.
- R4: redirectAddr equals the page register plus 0000FF90h. The page register resets to FFFF0000h, so redirectAddr is FFFFFF90h out of reset.
- R5: A request sampled at a clock edge while the unit is outside management mode raises redirect for exactly one cycle, starting right after that edge. inMgmt rises at the same time.
- R6: A request that arrives while inMgmt is high is held pending and does not raise redirect. It raises redirect in the cycle that follows the restore cycle.
- R7: A return sampled while inMgmt is high raises restore for exactly one cycle and clears inMgmt. During that cycle outCr0, outEflags, outCsLimit, outCsBase, outEip and outCsSel carry the six saved values.
- R8: A return sampled while inMgmt is low is ignored: restore stays low and the output state stays unchanged.
- R9: rdData returns 0 when inMgmt is low or when rdIdx is outside 25..31.
- R10: A write with pageWe loads pageWdata into the page register, and the next entry uses it. With the page at 000A0000h, redirectAddr is 000AFF90h.
- R11: After reset, redirect, restore and inMgmt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extReq | input | 1 | External management interrupt request |
| monReq | input | 1 | Privilege monitor event |
| trapReq | input | 1 | Opcode trap event |
| brkReq | input | 1 | Break instruction decoded |
| retReq | input | 1 | Return instruction decoded |
| liveCr0 | input | 32 | Current CR0 |
| liveEflags | input | 32 | Current EFLAGS |
| liveCsLimit | input | 32 | Current CS limit |
| liveCsBase | input | 32 | Current CS base |
| liveEip | input | 32 | Current EIP |
| liveCsSel | input | 16 | Current CS selector |
| pageWe | input | 1 | Page register write enable |
| pageWdata | input | 32 | Page register write data |
| rdIdx | input | 5 | Shadow slot read index |
| rdData | output | 32 | Shadow slot read data |
| redirect | output | 1 | One-cycle entry strobe |
| restore | output | 1 | One-cycle return strobe |
| inMgmt | output | 1 | Management mode active |
| redirectAddr | output | 32 | Entry target address |
| outCr0 | output | 32 | CR0 value for the core to load |
| outEflags | output | 32 | EFLAGS value for the core to load |
| outCsLimit | output | 32 | CS limit for the core to load |
| outCsBase | output | 32 | CS base for the core to load |
| outEip | output | 32 | EIP for the core to load |
| outCsSel | output | 16 | CS selector for the core to load |

## Verification
The bench steps through all fifteen non-empty combinations of the four request lines. For each one it checks the order in which the sources are taken and the code left in slot 26. A mistake in the priority order would show up as the wrong cause code, and a pending bit that is lost or cleared twice would show up as a missing or extra redirect. Directed tests cover a request raised during management mode, a return issued outside it, reads at the edges of the slot range, and the entry address both at its reset value and after a page write. A design that let a held request through early would redirect while inMgmt is still high. A design that honoured a stray return would pulse restore and overwrite the core state.

// File: rtl/mmcs_pkg.sv
package mmcs_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_EXT  = 3'd1,
    CAUSE_MON  = 3'd2,
    CAUSE_TRAP = 3'd3,
    CAUSE_BRK  = 3'd4
  } cause_e;

  typedef struct packed {
    logic   saveEn;
    logic   restoreEn;
    cause_e cause;
  } strobe_t;

  localparam int SLOT_LO    = 25;
  localparam int SLOT_HI    = 31;
  localparam int SLOT_N     = SLOT_HI - SLOT_LO + 1;
  localparam int SLOT_SEL   = 25;
  localparam int SLOT_CAUSE = 26;
  localparam int SLOT_EIP   = 27;
  localparam int SLOT_BASE  = 28;
  localparam int SLOT_LIM   = 29;
  localparam int SLOT_FLAGS = 30;
  localparam int SLOT_CR0   = 31;

endpackage

// File: rtl/mmcs_arbiter.sv
module mmcs_arbiter #(
  parameter int NSRC = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqIn,
  input  logic            holdOff,
  output logic            grantVld,
  output logic [IW-1:0]   grantIdx
);

  logic [NSRC-1:0] pendQ;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] grantOh;

  assign cand = pendQ | reqIn;

  // index 0 is highest priority: scan from the lowest so index 0 wins last
  always_comb begin
    grantOh  = '0;
    grantIdx = '0;
    grantVld = 1'b0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (cand[k] && !holdOff) begin
        grantOh     = '0;
        grantOh[k]  = 1'b1;
        grantIdx    = IW'(k);
        grantVld    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= cand[g] & ~grantOh[g];
    end
  end

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh));

  p_pending_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdOff && cand[0]) |=> pendQ[0]);

endmodule

// File: rtl/mmcs_ctrl.sv
module mmcs_ctrl
  import mmcs_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqIn,
  input  logic            retReq,
  output strobe_t         strb,
  output logic            redirect,
  output logic            restore,
  output logic            inMgmt
);

  logic          grantVld;
  logic [IW-1:0] grantIdx;
  logic          inMgmtQ;
  logic          redirectQ;
  logic          restoreQ;

  mmcs_arbiter #(.NSRC(NSRC)) uArb (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .holdOff  (inMgmtQ),
    .grantVld (grantVld),
    .grantIdx (grantIdx)
  );

  always_comb begin
    strb.saveEn    = grantVld;
    strb.restoreEn = inMgmtQ & retReq;
    strb.cause     = grantVld ? cause_e'(3'(grantIdx) + 3'd1) : CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMgmtQ   <= 1'b0;
      redirectQ <= 1'b0;
      restoreQ  <= 1'b0;
    end else begin
      redirectQ <= strb.saveEn;
      restoreQ  <= strb.restoreEn;
      if (strb.saveEn)         inMgmtQ <= 1'b1;
      else if (strb.restoreEn) inMgmtQ <= 1'b0;
    end
  end

  assign redirect = redirectQ;
  assign restore  = restoreQ;
  assign inMgmt   = inMgmtQ;

  p_redirect_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  p_redirect_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> inMgmt);

  p_restore_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    restore |-> (!inMgmt && $past(inMgmt)));

  p_ret_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!inMgmt && retReq) |=> !restore);

endmodule

// File: rtl/mmcs_datapath.sv
module mmcs_datapath
  import mmcs_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          SELW      = 16,
  parameter logic [31:0] ENTRY_OFF = 32'h0000_FF90,
  parameter logic [31:0] PAGE_RST  = 32'hFFFF_0000,
  parameter logic [31:0] RM_LIMIT  = 32'h0000_FFFF,
  parameter int          IF_BIT    = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic            inMgmt,
  input  logic            redirect,
  input  logic [XLEN-1:0] liveCr0,
  input  logic [XLEN-1:0] liveEflags,
  input  logic [XLEN-1:0] liveCsLimit,
  input  logic [XLEN-1:0] liveCsBase,
  input  logic [XLEN-1:0] liveEip,
  input  logic [SELW-1:0] liveCsSel,
  input  logic            pageWe,
  input  logic [XLEN-1:0] pageWdata,
  input  logic [4:0]      rdIdx,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] redirectAddr,
  output logic [XLEN-1:0] outCr0,
  output logic [XLEN-1:0] outEflags,
  output logic [XLEN-1:0] outCsLimit,
  output logic [XLEN-1:0] outCsBase,
  output logic [XLEN-1:0] outEip,
  output logic [SELW-1:0] outCsSel
);

  localparam logic [XLEN-1:0] OFF_X    = XLEN'(ENTRY_OFF);
  localparam logic [XLEN-1:0] ADDR_RST = XLEN'(PAGE_RST) + OFF_X;
  localparam logic [XLEN-1:0] CR0_KEEP = ~((XLEN'(1) << (XLEN - 1)) | XLEN'(1));
  localparam logic [XLEN-1:0] FL_KEEP  = ~(XLEN'(1) << IF_BIT);

  logic [XLEN-1:0] pageQ;
  logic [XLEN-1:0] bank    [SLOT_N];
  logic [XLEN-1:0] saveVal [SLOT_N];

  // page register
  always_ff @(posedge clk) begin
    if (!rstN)       pageQ <= XLEN'(PAGE_RST);
    else if (pageWe) pageQ <= pageWdata;
  end

  // value captured per slot on entry
  always_comb begin
    saveVal[SLOT_SEL   - SLOT_LO] = XLEN'(liveCsSel);
    saveVal[SLOT_CAUSE - SLOT_LO] = XLEN'(strb.cause);
    saveVal[SLOT_EIP   - SLOT_LO] = liveEip;
    saveVal[SLOT_BASE  - SLOT_LO] = liveCsBase;
    saveVal[SLOT_LIM   - SLOT_LO] = liveCsLimit;
    saveVal[SLOT_FLAGS - SLOT_LO] = liveEflags;
    saveVal[SLOT_CR0   - SLOT_LO] = liveCr0;
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)            bank[s] <= '0;
      else if (strb.saveEn) bank[s] <= saveVal[s];
    end
  end

  // state handed to the core: forced on entry, saved copy on return
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCr0       <= '0;
      outEflags    <= '0;
      outCsLimit   <= '0;
      outCsBase    <= '0;
      outEip       <= '0;
      outCsSel     <= '0;
      redirectAddr <= ADDR_RST;
    end else if (strb.saveEn) begin
      outCr0       <= liveCr0 & CR0_KEEP;
      outEflags    <= liveEflags & FL_KEEP;
      outCsLimit   <= XLEN'(RM_LIMIT);
      outCsBase    <= pageQ;
      outEip       <= OFF_X;
      outCsSel     <= pageQ[SELW+3:4];
      redirectAddr <= pageQ + OFF_X;
    end else if (strb.restoreEn) begin
      outCr0       <= bank[SLOT_CR0   - SLOT_LO];
      outEflags    <= bank[SLOT_FLAGS - SLOT_LO];
      outCsLimit   <= bank[SLOT_LIM   - SLOT_LO];
      outCsBase    <= bank[SLOT_BASE  - SLOT_LO];
      outEip       <= bank[SLOT_EIP   - SLOT_LO];
      outCsSel     <= bank[SLOT_SEL   - SLOT_LO][SELW-1:0];
    end
  end

  // software read port, live only in management mode
  always_comb begin
    rdData = '0;
    if (inMgmt && (int'(rdIdx) >= SLOT_LO) && (int'(rdIdx) <= SLOT_HI))
      rdData = bank[int'(rdIdx) - SLOT_LO];
  end

  p_forced_cr0_r3: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (!outCr0[0] && !outCr0[XLEN-1] && !outEflags[IF_BIT]));

  p_entry_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (redirectAddr == outCsBase + OFF_X));

  p_rd_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inMgmt |-> (rdData == '0));

endmodule

// File: rtl/mmcs_top.sv
module mmcs_top
  import mmcs_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            extReq,
  input  logic            monReq,
  input  logic            trapReq,
  input  logic            brkReq,
  input  logic            retReq,
  input  logic [XLEN-1:0] liveCr0,
  input  logic [XLEN-1:0] liveEflags,
  input  logic [XLEN-1:0] liveCsLimit,
  input  logic [XLEN-1:0] liveCsBase,
  input  logic [XLEN-1:0] liveEip,
  input  logic [SELW-1:0] liveCsSel,
  input  logic            pageWe,
  input  logic [XLEN-1:0] pageWdata,
  input  logic [4:0]      rdIdx,
  output logic [XLEN-1:0] rdData,
  output logic            redirect,
  output logic            restore,
  output logic            inMgmt,
  output logic [XLEN-1:0] redirectAddr,
  output logic [XLEN-1:0] outCr0,
  output logic [XLEN-1:0] outEflags,
  output logic [XLEN-1:0] outCsLimit,
  output logic [XLEN-1:0] outCsBase,
  output logic [XLEN-1:0] outEip,
  output logic [SELW-1:0] outCsSel
);

  strobe_t    strb;
  logic [3:0] reqVec;

  // bit 0 is highest priority
  assign reqVec = {brkReq, trapReq, monReq, extReq};

  mmcs_ctrl #(.NSRC(4)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqVec),
    .retReq   (retReq),
    .strb     (strb),
    .redirect (redirect),
    .restore  (restore),
    .inMgmt   (inMgmt)
  );

  mmcs_datapath #(.XLEN(XLEN), .SELW(SELW)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .inMgmt       (inMgmt),
    .redirect     (redirect),
    .liveCr0      (liveCr0),
    .liveEflags   (liveEflags),
    .liveCsLimit  (liveCsLimit),
    .liveCsBase   (liveCsBase),
    .liveEip      (liveEip),
    .liveCsSel    (liveCsSel),
    .pageWe       (pageWe),
    .pageWdata    (pageWdata),
    .rdIdx        (rdIdx),
    .rdData       (rdData),
    .redirectAddr (redirectAddr),
    .outCr0       (outCr0),
    .outEflags    (outEflags),
    .outCsLimit   (outCsLimit),
    .outCsBase    (outCsBase),
    .outEip       (outEip),
    .outCsSel     (outCsSel)
  );

endmodule

// File: tb/tb_mmcs_top.sv
module tb_mmcs_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        extReq, monReq, trapReq, brkReq, retReq;
  logic [31:0] liveCr0, liveEflags, liveCsLimit, liveCsBase, liveEip;
  logic [15:0] liveCsSel;
  logic        pageWe;
  logic [31:0] pageWdata;
  logic [4:0]  rdIdx;
  logic [31:0] rdData, redirectAddr;
  logic        redirect, restore, inMgmt;
  logic [31:0] outCr0, outEflags, outCsLimit, outCsBase, outEip;
  logic [15:0] outCsSel;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  mmcs_top dut (
    .clk(clk), .rstN(rstN), .extReq(extReq), .monReq(monReq), .trapReq(trapReq),
    .brkReq(brkReq), .retReq(retReq), .liveCr0(liveCr0), .liveEflags(liveEflags),
    .liveCsLimit(liveCsLimit), .liveCsBase(liveCsBase), .liveEip(liveEip),
    .liveCsSel(liveCsSel), .pageWe(pageWe), .pageWdata(pageWdata), .rdIdx(rdIdx),
    .rdData(rdData), .redirect(redirect), .restore(restore), .inMgmt(inMgmt),
    .redirectAddr(redirectAddr), .outCr0(outCr0), .outEflags(outEflags),
    .outCsLimit(outCsLimit), .outCsBase(outCsBase), .outEip(outEip), .outCsSel(outCsSel)
  );

  // {ext, mon, trap, brk} request pattern, expected first cause code (R1)
  localparam logic [6:0] VEC [15] = '{
    {4'b0001, 3'd4}, {4'b0010, 3'd3}, {4'b0011, 3'd3}, {4'b0100, 3'd2},
    {4'b0101, 3'd2}, {4'b0110, 3'd2}, {4'b0111, 3'd2}, {4'b1000, 3'd1},
    {4'b1001, 3'd1}, {4'b1010, 3'd1}, {4'b1011, 3'd1}, {4'b1100, 3'd1},
    {4'b1101, 3'd1}, {4'b1110, 3'd1}, {4'b1111, 3'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // highest-priority cause among a {ext,mon,trap,brk} pattern
  function automatic logic [2:0] topCause(input logic [3:0] m);
    if (m[3])      return 3'd1;
    else if (m[2]) return 3'd2;
    else if (m[1]) return 3'd3;
    else if (m[0]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [3:0] causeBit(input logic [2:0] c);
    case (c)
      3'd1:    return 4'b1000;
      3'd2:    return 4'b0100;
      3'd3:    return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic setLive(input int s);
    liveCr0     = 32'h8000_0011 | (32'(s) << 8);
    liveEflags  = 32'h0000_0202 | (32'(s) << 12);
    liveCsLimit = 32'h000F_FFFF - 32'(s);
    liveCsBase  = 32'h0010_0000 * (32'(s) + 1);
    liveEip     = 32'h0000_1000 + 32'(s) * 16;
    liveCsSel   = 16'h0008 + 16'(s) * 8;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReturn(input string tag);
    retReq = 1'b1;
    tick();
    retReq = 1'b0;
    chk(restore == 1'b1, {tag, " restore strobe"}, 32'(restore), 32'd1);
    chk(inMgmt == 1'b0, {tag, " inMgmt cleared"}, 32'(inMgmt), 32'd0);
    chk(outEip == liveEip, {tag, " restored eip"}, outEip, liveEip);
    chk(outCr0 == liveCr0, {tag, " restored cr0"}, outCr0, liveCr0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [3:0] rem;
    logic [2:0] exp;
    rstN = 1'b0; extReq = 0; monReq = 0; trapReq = 0; brkReq = 0; retReq = 0;
    pageWe = 0; pageWdata = '0; rdIdx = 5'd31;
    setLive(0);
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R11 reset state, R4 reset entry address, R9 idle read
    chk(redirect == 0 && restore == 0, "R11 strobes low", {30'd0, redirect, restore}, 32'd0);
    chk(inMgmt == 0, "R11 inMgmt low", 32'(inMgmt), 32'd0);
    chk(redirectAddr == 32'hFFFF_FF90, "R4 reset address", redirectAddr, 32'hFFFF_FF90);
    chk(rdData == 0, "R9 idle read zero", rdData, 32'd0);

    // R8 stray return while idle
    retReq = 1'b1;
    tick();
    retReq = 1'b0;
    chk(restore == 0, "R8 idle return ignored", 32'(restore), 32'd0);
    chk(outEip == 0, "R8 outputs unchanged", outEip, 32'd0);

    // single break entry with reset page: R5, R3, R2, R4
    setLive(7);
    brkReq = 1'b1;
    tick();
    brkReq = 1'b0;
    chk(redirect == 1, "R5 redirect raised", 32'(redirect), 32'd1);
    chk(inMgmt == 1, "R5 inMgmt raised", 32'(inMgmt), 32'd1);
    chk(redirectAddr == 32'hFFFF_FF90, "R4 default entry", redirectAddr, 32'hFFFF_FF90);
    chk(outCr0 == (liveCr0 & 32'h7FFF_FFFE), "R3 forced cr0", outCr0, liveCr0 & 32'h7FFF_FFFE);
    chk(outEflags == (liveEflags & ~32'h200), "R3 forced eflags", outEflags, liveEflags & ~32'h200);
    chk(outCsLimit == 32'h0000_FFFF, "R3 cs limit", outCsLimit, 32'h0000_FFFF);
    chk(outCsBase == 32'hFFFF_0000, "R3 cs base", outCsBase, 32'hFFFF_0000);
    chk(outEip == 32'h0000_FF90, "R3 eip", outEip, 32'h0000_FF90);
    chk(outCsSel == 16'hF000, "R3 cs sel", 32'(outCsSel), 32'h0000_F000);
    rdIdx = 5'd31; #1 chk(rdData == liveCr0, "R2 slot31 cr0", rdData, liveCr0);
    rdIdx = 5'd30; #1 chk(rdData == liveEflags, "R2 slot30 eflags", rdData, liveEflags);
    rdIdx = 5'd29; #1 chk(rdData == liveCsLimit, "R2 slot29 limit", rdData, liveCsLimit);
    rdIdx = 5'd28; #1 chk(rdData == liveCsBase, "R2 slot28 base", rdData, liveCsBase);
    rdIdx = 5'd27; #1 chk(rdData == liveEip, "R2 slot27 eip", rdData, liveEip);
    rdIdx = 5'd25; #1 chk(rdData == 32'(liveCsSel), "R2 slot25 sel", rdData, 32'(liveCsSel));
    rdIdx = 5'd26; #1 chk(rdData == 32'd4, "R1 break cause", rdData, 32'd4);
    rdIdx = 5'd24; #1 chk(rdData == 0, "R9 index below range", rdData, 32'd0);
    tick();
    chk(redirect == 0, "R5 redirect one cycle", 32'(redirect), 32'd0);
    doReturn("R7");
    chk(outCsLimit == liveCsLimit && outCsSel == liveCsSel, "R7 restored cs",
        outCsLimit, liveCsLimit);
    rdIdx = 5'd31; #1 chk(rdData == 0, "R9 read after return", rdData, 32'd0);
    tick();
    chk(restore == 0, "R7 restore one cycle", 32'(restore), 32'd0);

    // R10 page write
    pageWe = 1'b1; pageWdata = 32'h000A_0000;
    tick();
    pageWe = 1'b0;

    // table walk over all request patterns: R1, R6, R10
    for (int i = 0; i < 15; i++) begin
      setLive(i + 1);
      {extReq, monReq, trapReq, brkReq} = VEC[i][6:3];
      rem = VEC[i][6:3];
      exp = VEC[i][2:0];
      chk(topCause(rem) == exp, "R1 table consistency", 32'(topCause(rem)), 32'(exp));
      tick();
      {extReq, monReq, trapReq, brkReq} = 4'b0000;
      while (rem != 4'b0000) begin
        exp = topCause(rem);
        chk(redirect == 1, "R6 redirect for held request", 32'(redirect), 32'd1);
        rdIdx = 5'd26; #1
        chk(rdData == 32'(exp), "R1 cause order", rdData, 32'(exp));
        chk(redirectAddr == 32'h000A_FF90, "R10 entry address", redirectAddr, 32'h000A_FF90);
        rem = rem & ~causeBit(exp);
        doReturn("R7 table");
        if (rem != 4'b0000) tick();
      end
      tick();
      chk(redirect == 0, "R6 no extra entry", 32'(redirect), 32'd0);
    end

    // R6 request raised while in management mode
    setLive(3);
    trapReq = 1'b1;
    tick();
    trapReq = 1'b0;
    chk(redirect == 1, "R5 trap entry", 32'(redirect), 32'd1);
    extReq = 1'b1;
    tick();
    extReq = 1'b0;
    repeat (2) begin
      chk(redirect == 0 && inMgmt == 1, "R6 held while active", 32'(redirect), 32'd0);
      tick();
    end
    doReturn("R6");
    tick();
    chk(redirect == 1, "R6 held request taken after restore", 32'(redirect), 32'd1);
    rdIdx = 5'd26; #1 chk(rdData == 32'd1, "R6 held cause ext", rdData, 32'd1);
    doReturn("R6 final");
    tick();

    summary();
  end

endmodule